// File: doc/BRIEF.md
# Page-Granular Peripheral Dispatch Router

This block sits between a CPU access port and a set of peripheral targets. It claims the accesses that land inside a fixed address window and picks a target for each one. The choice comes from a lookup table that software can write, not from fixed address comparators. The window is split into 4 KiB pages, and each page holds three target indices, one for each access width (byte, halfword, word). A single page can therefore send accesses of different widths to different handlers. Index 0 means the slot is unmapped.

Software fills the table with attach commands. Each command gives:
- a region number and the agent's region count,
- a byte offset into the window and a byte size,
- a target index,
- a mask of the widths to write.

An attach state machine checks the command. If it is valid, the machine writes the index into one page per cycle. Requests are held off while it does this. A request that is forwarded gets its response one cycle later, carrying the target's read data. A request to an unmapped slot, to an address outside the window, or with the reserved size code is answered with zero data and a decode-error flag.

The attach state machine has four states:
- `S_IDLE`: waits for a command and accepts it.
  - Transition *reject*: a bad command goes to `S_REJECT`.
  - Transition *skip*: a command with index 0 or zero pages goes to `S_FINISH`.
  - Transition *start*: any other valid command goes to `S_FILL`.
- `S_FILL`: writes one page entry per cycle.
  - Transition *last*: after the final page it goes to `S_FINISH`.
- `S_FINISH`: pulses done and returns to `S_IDLE` (transition *return*).
- `S_REJECT`: pulses done with error and returns to `S_IDLE` (transition *return*).

Top module: `page_dispatch_router`

## Requirements
- R1: After reset every table slot is unmapped, `cfg_ready` and `req_ready` are 1, and `cfg_busy` is 0.
- R2: The page index of a request is (`req_addr` − WIN_BASE) >> 12. The slot used within that page is chosen by `req_size`: 0 = byte, 1 = halfword, 2 = word. `tgt_idx` shows the index stored in that slot, in the same cycle as the request, and `tgt_offs` shows `req_addr` − WIN_BASE.
- R3: An accepted attach with a nonzero index writes that index into ceil(`cfg_size`/4096) consecutive pages. The first page is `cfg_offs` >> 12. Pages outside the run and widths not set in `cfg_wmask` (bit n = size code n) keep their old entries.
- R4: Different widths of the same page can be mapped to different indices, and each width routes independently.
- R5: An attach is rejected if any of these holds: `cfg_region` is negative (two's complement), `cfg_region` ≥ `cfg_nregions`, `cfg_idx` > 125, or `cfg_offs` ≥ 0xB4000. A rejected attach pulses `cfg_done` together with `cfg_err` and leaves the table unchanged.
- R6: An attach with `cfg_idx` = 0 writes nothing. It pulses `cfg_done` without an error, and `cfg_base` = WIN_BASE + `cfg_offs`.
- R7: `cfg_base` = WIN_BASE + `cfg_offs` whenever `cfg_done` is 1 after an attach that was not rejected.
- R8: A request is a decode error if its slot holds 0, its address is outside the window, or its size code is 3. A decode error is not forwarded (`tgt_valid` = 0), so a write is ignored. Its response carries `rsp_rdata` = 0 and `rsp_derr` = 1.
- R9: While the attach machine is not in `S_IDLE`, `cfg_busy` is 1 and `req_ready` and `cfg_ready` are 0.
- R10: `rsp_valid` is 1 exactly one cycle after an accepted request. For a forwarded read, `rsp_rdata` is the `tgt_rdata` value from the request cycle. For a forwarded write, `rsp_rdata` is 0.
- R11: A page run that extends past the last page is clipped at the window end, and the attach still completes without error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | CPU request present |
| req_ready | output | 1 | Request accepted this cycle |
| req_addr | input | ADDR_W (32) | Request address |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| req_we | input | 1 | 1 = write |
| req_wdata | input | DATA_W (32) | Write data |
| tgt_valid | output | 1 | Request forwarded to a target |
| tgt_idx | output | IDX_W (7) | Selected target index |
| tgt_size | output | 2 | Forwarded size |
| tgt_we | output | 1 | Forwarded write strobe |
| tgt_offs | output | OFFS_W (20) | Offset within the window |
| tgt_wdata | output | DATA_W (32) | Forwarded write data |
| tgt_rdata | input | DATA_W (32) | Read data from the selected target |
| rsp_valid | output | 1 | Response present |
| rsp_rdata | output | DATA_W (32) | Response read data |
| rsp_derr | output | 1 | Decode error |
| cfg_valid | input | 1 | Attach command present |
| cfg_ready | output | 1 | Attach command accepted |
| cfg_region | input | REG_W (8) | Region number, signed |
| cfg_nregions | input | REG_W (8) | Agent region count |
| cfg_offs | input | OFFS_W (20) | Region byte offset in the window |
| cfg_size | input | SIZE_W (21) | Region byte size |
| cfg_idx | input | IDX_W (7) | Target index to map |
| cfg_wmask | input | 3 | Widths to map |
| cfg_busy | output | 1 | Attach machine active |
| cfg_done | output | 1 | Attach finished (one cycle) |
| cfg_err | output | 1 | Attach rejected (with done) |
| cfg_base | output | ADDR_W (32) | Absolute base of the attached region |

## Verification
Two situations are hard to reach from the ports. The first is a page run that crosses the top of the window, where the fill must stop at the last page and must not wrap. The bench gets there with an attach whose offset is in the final page and whose size covers three pages. It then probes the last word inside the window and the first address past it. The second is a request arriving while the fill is in progress. The bench checks `req_ready` and `cfg_busy` on the cycle after it issues a multi-page attach.

// File: rtl/pdr_pkg.sv
package pdr_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_BAD  = 2'd3
    } acc_size_e;

    localparam int NUM_SLOTS = 3;
endpackage

// File: rtl/pdr_decode.sv
module pdr_decode #(
    parameter int                ADDR_W    = 32,
    parameter logic [ADDR_W-1:0] WIN_BASE  = 'h4800_0000,
    parameter int                WIN_BYTES = 'hB4000,
    parameter int                PAGE_BITS = 12,
    parameter int                OFFS_W    = 20,
    parameter int                PG_W      = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    output logic              in_win,
    output logic              size_ok,
    output logic [OFFS_W-1:0] offs,
    output logic [PG_W-1:0]   page
);
    import pdr_pkg::*;

    logic [ADDR_W-1:0] rel;

    always_comb begin
        rel     = addr - WIN_BASE;
        in_win  = (addr >= WIN_BASE) && (rel < ADDR_W'(WIN_BYTES));
        size_ok = (size != SZ_BAD);
        offs    = rel[OFFS_W-1:0];
        page    = in_win ? rel[PAGE_BITS +: PG_W] : '0;
    end
endmodule

// File: rtl/pdr_page_table.sv
module pdr_page_table #(
    parameter int PAGES = 180,
    parameter int PG_W  = 8,
    parameter int IDX_W = 7
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [PG_W-1:0]                wr_page,
    input  logic [pdr_pkg::NUM_SLOTS-1:0]  wr_mask,
    input  logic [IDX_W-1:0]               wr_idx,
    input  logic [PG_W-1:0]                rd_page,
    input  logic [1:0]                     rd_slot,
    output logic [IDX_W-1:0]               rd_idx
);
    import pdr_pkg::*;

    logic [IDX_W-1:0] ent [PAGES][NUM_SLOTS];

    for (genvar p = 0; p < PAGES; p++) begin : g_page
        for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    ent[p][s] <= '0;
                else if (wr_en && wr_page == PG_W'(p) && wr_mask[s])
                    ent[p][s] <= wr_idx;
            end
        end
    end

    always_comb begin
        rd_idx = '0;
        if (int'(rd_slot) < NUM_SLOTS && int'(rd_page) < PAGES)
            rd_idx = ent[rd_page][rd_slot];
    end

    // R6
    zero_idx_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_idx != '0));
endmodule

// File: rtl/pdr_attach_fsm.sv
module pdr_attach_fsm #(
    parameter int                ADDR_W    = 32,
    parameter logic [ADDR_W-1:0] WIN_BASE  = 'h4800_0000,
    parameter int                WIN_BYTES = 'hB4000,
    parameter int                PAGE_BITS = 12,
    parameter int                PAGES     = 180,
    parameter int                PG_W      = 8,
    parameter int                OFFS_W    = 20,
    parameter int                SIZE_W    = 21,
    parameter int                IDX_W     = 7,
    parameter int                MAX_IDX   = 125,
    parameter int                REG_W     = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cfg_valid,
    input  logic [REG_W-1:0]              cfg_region,
    input  logic [REG_W-1:0]              cfg_nregions,
    input  logic [OFFS_W-1:0]             cfg_offs,
    input  logic [SIZE_W-1:0]             cfg_size,
    input  logic [IDX_W-1:0]              cfg_idx,
    input  logic [pdr_pkg::NUM_SLOTS-1:0] cfg_wmask,
    output logic                          cfg_ready,
    output logic                          cfg_busy,
    output logic                          cfg_done,
    output logic                          cfg_err,
    output logic [ADDR_W-1:0]             cfg_base,
    output logic                          wr_en,
    output logic [PG_W-1:0]               wr_page,
    output logic [pdr_pkg::NUM_SLOTS-1:0] wr_mask,
    output logic [IDX_W-1:0]              wr_idx
);
    import pdr_pkg::*;

    localparam int CNT_W = SIZE_W - PAGE_BITS + 1;
    localparam int PAGE_BYTES = 1 << PAGE_BITS;

    typedef enum logic [1:0] {S_IDLE, S_FILL, S_FINISH, S_REJECT} att_state_e;

    att_state_e state, state_nx;
    logic [PG_W-1:0]      ptr;
    logic [CNT_W-1:0]     left;
    logic [IDX_W-1:0]     idx_q;
    logic [NUM_SLOTS-1:0] mask_q;
    logic [ADDR_W-1:0]    base_q;

    logic              bad_cmd;
    logic [SIZE_W:0]   size_up;
    logic [CNT_W-1:0]  npg, avail, take;
    logic [PG_W-1:0]   start_pg;

    always_comb begin
        bad_cmd  = cfg_region[REG_W-1]
                 || ({1'b0, cfg_region[REG_W-2:0]} >= cfg_nregions)
                 || (int'(cfg_idx) > MAX_IDX)
                 || (int'(cfg_offs) >= WIN_BYTES);
        size_up  = {1'b0, cfg_size} + (SIZE_W+1)'(PAGE_BYTES - 1);
        npg      = size_up[SIZE_W:PAGE_BITS];
        start_pg = cfg_offs[PAGE_BITS +: PG_W];
        avail    = CNT_W'(PAGES) - CNT_W'(start_pg);
        take     = (npg < avail) ? npg : avail;
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: if (cfg_valid) begin
                if (bad_cmd)                            state_nx = S_REJECT;
                else if (cfg_idx == '0 || take == '0)   state_nx = S_FINISH;
                else                                    state_nx = S_FILL;
            end
            S_FILL:   if (left == CNT_W'(1)) state_nx = S_FINISH;
            S_FINISH: state_nx = S_IDLE;
            S_REJECT: state_nx = S_IDLE;
            default:  state_nx = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // command datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr    <= '0;
            left   <= '0;
            idx_q  <= '0;
            mask_q <= '0;
            base_q <= '0;
        end else if (state == S_IDLE && cfg_valid) begin
            ptr    <= start_pg;
            left   <= take;
            idx_q  <= cfg_idx;
            mask_q <= cfg_wmask;
            base_q <= WIN_BASE + ADDR_W'(cfg_offs);
        end else if (state == S_FILL) begin
            ptr  <= ptr + PG_W'(1);
            left <= left - CNT_W'(1);
        end
    end

    // outputs
    always_comb begin
        cfg_ready = 1'b0;
        cfg_busy  = 1'b1;
        cfg_done  = 1'b0;
        cfg_err   = 1'b0;
        wr_en     = 1'b0;
        unique case (state)
            S_IDLE:   begin cfg_ready = 1'b1; cfg_busy = 1'b0; end
            S_FILL:   wr_en = 1'b1;
            S_FINISH: cfg_done = 1'b1;
            S_REJECT: begin cfg_done = 1'b1; cfg_err = 1'b1; end
            default:  cfg_busy = 1'b1;
        endcase
        wr_page  = ptr;
        wr_mask  = mask_q;
        wr_idx   = idx_q;
        cfg_base = base_q;
    end

    // R3
    fill_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_FILL) |-> (left != '0));
    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_done |=> !cfg_done);
endmodule

// File: rtl/page_dispatch_router.sv
module page_dispatch_router #(
    parameter int                ADDR_W    = 32,
    parameter int                DATA_W    = 32,
    parameter logic [ADDR_W-1:0] WIN_BASE  = 'h4800_0000,
    parameter int                WIN_BYTES = 'hB4000,
    parameter int                PAGE_BITS = 12,
    parameter int                IDX_W     = 7,
    parameter int                MAX_IDX   = 125,
    parameter int                REG_W     = 8,
    parameter int                SIZE_W    = 21,
    localparam int               PAGES     = WIN_BYTES >> PAGE_BITS,
    localparam int               PG_W      = $clog2(PAGES),
    localparam int               OFFS_W    = $clog2(WIN_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic              req_we,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              tgt_valid,
    output logic [IDX_W-1:0]  tgt_idx,
    output logic [1:0]        tgt_size,
    output logic              tgt_we,
    output logic [OFFS_W-1:0] tgt_offs,
    output logic [DATA_W-1:0] tgt_wdata,
    input  logic [DATA_W-1:0] tgt_rdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_derr,
    input  logic              cfg_valid,
    output logic              cfg_ready,
    input  logic [REG_W-1:0]  cfg_region,
    input  logic [REG_W-1:0]  cfg_nregions,
    input  logic [OFFS_W-1:0] cfg_offs,
    input  logic [SIZE_W-1:0] cfg_size,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [2:0]        cfg_wmask,
    output logic              cfg_busy,
    output logic              cfg_done,
    output logic              cfg_err,
    output logic [ADDR_W-1:0] cfg_base
);
    import pdr_pkg::*;

    logic                 wr_en;
    logic [PG_W-1:0]      wr_page;
    logic [NUM_SLOTS-1:0] wr_mask;
    logic [IDX_W-1:0]     wr_idx;
    logic                 in_win, size_ok;
    logic [PG_W-1:0]      page;
    logic [IDX_W-1:0]     slot_idx;
    logic                 fire, hit;

    pdr_decode #(
        .ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .WIN_BYTES(WIN_BYTES),
        .PAGE_BITS(PAGE_BITS), .OFFS_W(OFFS_W), .PG_W(PG_W)
    ) u_decode (
        .addr(req_addr), .size(req_size), .in_win(in_win),
        .size_ok(size_ok), .offs(tgt_offs), .page(page)
    );

    pdr_page_table #(.PAGES(PAGES), .PG_W(PG_W), .IDX_W(IDX_W)) u_table (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_page(wr_page),
        .wr_mask(wr_mask), .wr_idx(wr_idx), .rd_page(page),
        .rd_slot(req_size), .rd_idx(slot_idx)
    );

    pdr_attach_fsm #(
        .ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .WIN_BYTES(WIN_BYTES),
        .PAGE_BITS(PAGE_BITS), .PAGES(PAGES), .PG_W(PG_W), .OFFS_W(OFFS_W),
        .SIZE_W(SIZE_W), .IDX_W(IDX_W), .MAX_IDX(MAX_IDX), .REG_W(REG_W)
    ) u_attach (
        .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid),
        .cfg_region(cfg_region), .cfg_nregions(cfg_nregions),
        .cfg_offs(cfg_offs), .cfg_size(cfg_size), .cfg_idx(cfg_idx),
        .cfg_wmask(cfg_wmask), .cfg_ready(cfg_ready), .cfg_busy(cfg_busy),
        .cfg_done(cfg_done), .cfg_err(cfg_err), .cfg_base(cfg_base),
        .wr_en(wr_en), .wr_page(wr_page), .wr_mask(wr_mask), .wr_idx(wr_idx)
    );

    always_comb begin
        req_ready = !cfg_busy;
        fire      = req_valid && req_ready;
        hit       = fire && in_win && size_ok && (slot_idx != '0);
        tgt_valid = hit;
        tgt_idx   = slot_idx;
        tgt_size  = req_size;
        tgt_we    = req_we;
        tgt_wdata = req_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_derr  <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= fire;
            rsp_derr  <= fire && !hit;
            rsp_rdata <= (hit && !req_we) ? tgt_rdata : '0;
        end
    end

    // R8
    derr_zero_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_derr |-> (rsp_rdata == '0));
    // R10
    rsp_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid && req_ready));
    // R9
    no_fwd_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_valid |-> !cfg_busy);
    // R2
    tgt_idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_valid |-> (tgt_idx != '0 && int'(tgt_idx) <= MAX_IDX));
endmodule

// File: tb/page_dispatch_router_tb.sv
module page_dispatch_router_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] BASE = 32'h4800_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_we = 1'b0;
    logic [31:0] req_addr = '0, req_wdata = '0;
    logic [1:0]  req_size = '0;
    logic        req_ready, tgt_valid, tgt_we, rsp_valid, rsp_derr;
    logic [6:0]  tgt_idx;
    logic [1:0]  tgt_size;
    logic [19:0] tgt_offs;
    logic [31:0] tgt_wdata, tgt_rdata, rsp_rdata, cfg_base;
    logic        cfg_valid = 1'b0;
    logic [7:0]  cfg_region = '0, cfg_nregions = '0;
    logic [19:0] cfg_offs = '0;
    logic [20:0] cfg_size = '0;
    logic [6:0]  cfg_idx = '0;
    logic [2:0]  cfg_wmask = '0;
    logic        cfg_ready, cfg_busy, cfg_done, cfg_err;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // target model: data identifies target and offset
    assign tgt_rdata = {1'b0, tgt_idx, 4'h0, tgt_offs};

    page_dispatch_router u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_size(req_size), .req_we(req_we),
        .req_wdata(req_wdata), .tgt_valid(tgt_valid), .tgt_idx(tgt_idx),
        .tgt_size(tgt_size), .tgt_we(tgt_we), .tgt_offs(tgt_offs),
        .tgt_wdata(tgt_wdata), .tgt_rdata(tgt_rdata), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .rsp_derr(rsp_derr), .cfg_valid(cfg_valid),
        .cfg_ready(cfg_ready), .cfg_region(cfg_region),
        .cfg_nregions(cfg_nregions), .cfg_offs(cfg_offs), .cfg_size(cfg_size),
        .cfg_idx(cfg_idx), .cfg_wmask(cfg_wmask), .cfg_busy(cfg_busy),
        .cfg_done(cfg_done), .cfg_err(cfg_err), .cfg_base(cfg_base)
    );

    task automatic chk(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            chk(1'b0, "watchdog", cycles, 100000);
            finish_up();
        end
    end

    // one request; exp_idx 0 means decode error expected
    task automatic do_req(input string req, input logic [31:0] addr,
                          input logic [1:0] sz, input logic we, input logic [6:0] exp_idx);
        logic [19:0] eoffs;
        eoffs = 20'(addr - BASE);
        @(negedge clk);
        req_addr = addr; req_size = sz; req_we = we; req_wdata = 32'hCAFE_0000;
        req_valid = 1'b1;
        #1;
        chk(req_ready == 1'b1, req, {31'b0, req_ready}, 1);
        chk(tgt_valid == (exp_idx != 0), req, {31'b0, tgt_valid}, {31'b0, exp_idx != 0});
        if (exp_idx != 0) begin
            chk(tgt_idx == exp_idx, req, {25'b0, tgt_idx}, {25'b0, exp_idx});
            chk(tgt_offs == eoffs, req, {12'b0, tgt_offs}, {12'b0, eoffs});
        end
        @(negedge clk);
        req_valid = 1'b0;
        chk(rsp_valid == 1'b1, {req, "/R10"}, {31'b0, rsp_valid}, 1);
        chk(rsp_derr == (exp_idx == 0), {req, "/R8"}, {31'b0, rsp_derr},
            {31'b0, exp_idx == 0});
        if (exp_idx == 0 || we)
            chk(rsp_rdata == 0, {req, "/R8"}, rsp_rdata, 0);
        else
            chk(rsp_rdata == {1'b0, exp_idx, 4'h0, eoffs}, {req, "/R10"}, rsp_rdata,
                {1'b0, exp_idx, 4'h0, eoffs});
    endtask

    task automatic do_attach(input string req, input logic [7:0] region,
                             input logic [7:0] nreg, input logic [19:0] offs,
                             input logic [20:0] size, input logic [6:0] idx,
                             input logic [2:0] mask, input logic exp_err,
                             input logic exp_fill);
        int n;
        @(negedge clk);
        chk(cfg_ready == 1'b1, req, {31'b0, cfg_ready}, 1);
        cfg_region = region; cfg_nregions = nreg; cfg_offs = offs;
        cfg_size = size; cfg_idx = idx; cfg_wmask = mask; cfg_valid = 1'b1;
        @(negedge clk);
        cfg_valid = 1'b0;
        if (exp_fill) begin
            // R9: fill in progress blocks requests
            chk(cfg_busy == 1'b1, "R9 busy", {31'b0, cfg_busy}, 1);
            chk(req_ready == 1'b0, "R9 req_ready", {31'b0, req_ready}, 0);
            chk(cfg_ready == 1'b0, "R9 cfg_ready", {31'b0, cfg_ready}, 0);
        end
        n = 0;
        while (!cfg_done && n < 400) begin
            @(negedge clk);
            n++;
        end
        chk(cfg_done == 1'b1, {req, " done"}, {31'b0, cfg_done}, 1);
        chk(cfg_err == exp_err, {req, " err"}, {31'b0, cfg_err}, {31'b0, exp_err});
        if (!exp_err)
            chk(cfg_base == BASE + 32'(offs), {req, " R7 base"}, cfg_base,
                BASE + 32'(offs));
        @(negedge clk);
    endtask

    task automatic t_reset();
        #1;
        chk(cfg_ready && req_ready && !cfg_busy, "R1 idle", {29'b0, cfg_ready,
            req_ready, cfg_busy}, 3'b110);
        do_req("R1 unmapped p0", BASE, 2'd2, 1'b0, 0);
        do_req("R1 unmapped p100", BASE + 32'h64000, 2'd0, 1'b0, 0);
    endtask

    task automatic t_fill();
        // pages 2,3,4 all widths -> 5 (size 0x2001 rounds up to 3 pages)
        do_attach("R3 attach", 8'd0, 8'd2, 20'h02000, 21'h02001, 7'd5, 3'b111, 0, 1);
        do_req("R3 p2 word", BASE + 32'h2010, 2'd2, 1'b0, 5);
        do_req("R2 p3 half", BASE + 32'h3ABC, 2'd1, 1'b0, 5);
        do_req("R3 p4 byte", BASE + 32'h4FFF, 2'd0, 1'b0, 5);
        do_req("R3 p5 untouched", BASE + 32'h5000, 2'd2, 1'b0, 0);
        do_req("R3 p1 untouched", BASE + 32'h1FFC, 2'd2, 1'b0, 0);
        do_req("R10 write fwd", BASE + 32'h3000, 2'd2, 1'b1, 5);
        do_req("R8 write unmapped", BASE + 32'h7000, 2'd2, 1'b1, 0);
    endtask

    task automatic t_widths();
        do_attach("R4 attach byte", 8'd1, 8'd2, 20'h02000, 21'h01000, 7'd9, 3'b001, 0, 1);
        do_req("R4 p2 byte", BASE + 32'h2001, 2'd0, 1'b0, 9);
        do_req("R4 p2 word", BASE + 32'h2004, 2'd2, 1'b0, 5);
        do_attach("R4 attach half", 8'd0, 8'd1, 20'h08000, 21'h00800, 7'd33, 3'b010, 0, 1);
        do_req("R4 p8 half", BASE + 32'h8002, 2'd1, 1'b0, 33);
        do_req("R4 p8 word", BASE + 32'h8004, 2'd2, 1'b0, 0);
    endtask

    task automatic t_reject();
        do_attach("R5 negative", 8'hFF, 8'd2, 20'h02000, 21'h1000, 7'd12, 3'b111, 1, 0);
        do_attach("R5 region=cnt", 8'd2, 8'd2, 20'h02000, 21'h1000, 7'd12, 3'b111, 1, 0);
        do_attach("R5 idx 126", 8'd0, 8'd2, 20'h02000, 21'h1000, 7'd126, 3'b111, 1, 0);
        do_attach("R5 offs out", 8'd0, 8'd2, 20'hB4000, 21'h1000, 7'd12, 3'b111, 1, 0);
        do_req("R5 p2 unchanged", BASE + 32'h2000, 2'd2, 1'b0, 5);
        do_attach("R5 idx 125 ok", 8'd0, 8'd1, 20'h0A000, 21'h1000, 7'd125, 3'b100, 0, 1);
        do_req("R5 p10 word", BASE + 32'hA000, 2'd2, 1'b0, 125);
    endtask

    task automatic t_zero_idx();
        do_attach("R6 idx 0", 8'd0, 8'd1, 20'h03000, 21'h2000, 7'd0, 3'b111, 0, 0);
        do_req("R6 p3 unchanged", BASE + 32'h3000, 2'd2, 1'b0, 5);
        do_req("R6 p4 unchanged", BASE + 32'h4000, 2'd0, 1'b0, 5);
    endtask

    task automatic t_clip_and_edges();
        do_attach("R11 clip", 8'd0, 8'd1, 20'hB3000, 21'h03000, 7'd7, 3'b111, 0, 1);
        do_req("R11 last word", BASE + 32'hB3FFC, 2'd2, 1'b0, 7);
        do_req("R11 past window", BASE + 32'hB4000, 2'd2, 1'b0, 0);
        do_req("R2 below window", BASE - 32'd4, 2'd2, 1'b0, 0);
        do_req("R2 page 0 still empty", BASE, 2'd0, 1'b0, 0);
        do_req("R8 size code 3", BASE + 32'h2000, 2'd3, 1'b0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_fill();
        t_widths();
        t_reject();
        t_zero_idx();
        t_clip_and_edges();
        repeat (2) @(negedge clk);
        finish_up();
    end
endmodule